// File: doc/BRIEF.md
# Register Transfer and Exchange Unit

This block holds the programmer-visible data registers of a small 8/16-bit accumulator processor and carries out the register-to-register moves of its instruction set. It contains two 8-bit accumulators, A and B, and three 16-bit registers, X, Y and SP. The 16-bit pair D is not separate storage. It is A in the high byte and B in the low byte. It also holds the negative (N), zero (Z) and overflow (V) condition bits.

Each cycle the surrounding sequencer may present one command: a general transfer, a sign-extending transfer, a flag-setting accumulator-to-accumulator move, an exchange, or a load. The command names a source and a destination register with 3-bit select codes. Load values arrive on a plain data input. All register updates happen on the single clock edge that follows the command. The rules for moves between registers of different widths are fixed.

Top module: `regmove_unit`

## Requirements
- R1: While `rstN` is low, A, B, X, Y, SP and the flags N, Z and V are all cleared to zero.
- R2: Register select codes are 0=A, 1=B, 4=D (A:B), 5=X, 6=Y, 7=SP. A transfer (cmdOp=0) between two 16-bit registers copies all 16 bits. Writing D puts the high byte into A and the low byte into B.
- R3: A transfer (cmdOp=0) from an accumulator to a 16-bit register writes the byte sign-extended to 16 bits. The sign-extend command (cmdOp=3) does the same. It acts only when the source is an accumulator and the destination is a 16-bit register.
- R4: A transfer from a 16-bit register to an accumulator writes only the low byte of the source. With D as the source, that low byte is B.
- R5: The transfer command (cmdOp=0) and the sign-extend command (cmdOp=3) leave N, Z and V unchanged.
- R6: The accumulator move (cmdOp=4) copies A to B or B to A and sets N to bit 7 of the result. Z is set when the result byte is zero, and V is cleared. If either select is not an accumulator, the command is ignored.
- R7: An exchange (cmdOp=1) of two registers of equal width swaps both values on the same clock edge. This includes D against a 16-bit register.
- R8: An exchange between an accumulator and a 16-bit register puts the low byte of the 16-bit register into the accumulator. The 16-bit register receives 8'h00 joined with the old accumulator value. When the 16-bit side is D, its write is applied last. The result is A=8'h00 and B equal to the old accumulator.
- R9: A load (cmdOp=2) writes `loadData` to the destination, using the low byte for an accumulator. N and Z are set from the loaded value at the destination width (bit 7 or bit 15), and V is cleared.
- R10: The following commands change no register and no flag: any command while `cmdValid` is low, op codes 5 to 7, select codes 2 and 3, and a sign-extend command whose operands are not accumulator-to-16-bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdOp | input | 3 | 0 transfer, 1 exchange, 2 load, 3 sign-extend, 4 accumulator move |
| srcSel | input | 3 | Source register code |
| dstSel | input | 3 | Destination register code |
| loadData | input | 16 | Value for a load command |
| regA | output | 8 | Accumulator A |
| regB | output | 8 | Accumulator B |
| regX | output | 16 | Index register X |
| regY | output | 16 | Index register Y |
| regSp | output | 16 | Stack pointer |
| flagN | output | 1 | Negative condition bit |
| flagZ | output | 1 | Zero condition bit |
| flagV | output | 1 | Overflow condition bit |

## Verification
The bench targets the width-crossing cases. Sign-extending and zero-extending a byte with bit 7 set tells the two rules apart. A design that mixed them up would leave 8'hFF or 8'h00 in the wrong high byte. An exchange of an accumulator with D exposes the write ordering, because both sides touch A. A design that applied the 16-bit write first would leave the old low byte in A. Flag checks use values where the move would itself produce different N and Z than those already held. A transfer that wrongly updated the flags, or a load that took Z from sixteen bits when the destination is an accumulator, therefore shows a wrong value.

// File: rtl/regmove_pkg.sv
package regmove_pkg;
  localparam int ACC_W  = 8;
  localparam int WORD_W = 2 * ACC_W;
  localparam int SEL_W  = 3;
  localparam int OP_W   = 3;

  localparam logic [SEL_W-1:0] SEL_A  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_B  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_D  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_X  = 3'd5;
  localparam logic [SEL_W-1:0] SEL_Y  = 3'd6;
  localparam logic [SEL_W-1:0] SEL_SP = 3'd7;

  typedef enum logic [OP_W-1:0] {
    OP_XFER    = 3'd0,
    OP_SWAP    = 3'd1,
    OP_LOAD    = 3'd2,
    OP_SEXT    = 3'd3,
    OP_ACCMOVE = 3'd4
  } opT;

  typedef enum logic [1:0] {
    DS_COPY = 2'd0,
    DS_SEXT = 2'd1,
    DS_ZEXT = 2'd2,
    DS_LOAD = 2'd3
  } dataSrcT;

  typedef struct packed {
    logic             wrDst;
    logic             wrSrc;
    logic [SEL_W-1:0] dstSel;
    logic [SEL_W-1:0] srcSel;
    dataSrcT          dstData;
    logic             srcZext;
    logic             wideLast;
    logic             flagWr;
    logic             flagWide;
  } ctrlT;

  typedef struct packed {
    logic [ACC_W-1:0]  a;
    logic [ACC_W-1:0]  b;
    logic [WORD_W-1:0] x;
    logic [WORD_W-1:0] y;
    logic [WORD_W-1:0] sp;
  } regsT;

  function automatic logic isAcc(input logic [SEL_W-1:0] s);
    return (s == SEL_A) || (s == SEL_B);
  endfunction

  function automatic logic isWide(input logic [SEL_W-1:0] s);
    return (s == SEL_D) || (s == SEL_X) || (s == SEL_Y) || (s == SEL_SP);
  endfunction

  function automatic logic [WORD_W-1:0] readReg(input regsT r, input logic [SEL_W-1:0] s);
    logic [WORD_W-1:0] v;
    case (s)
      SEL_A:   v = {{ACC_W{1'b0}}, r.a};
      SEL_B:   v = {{ACC_W{1'b0}}, r.b};
      SEL_D:   v = {r.a, r.b};
      SEL_X:   v = r.x;
      SEL_Y:   v = r.y;
      SEL_SP:  v = r.sp;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic regsT writeReg(input regsT r, input logic [SEL_W-1:0] s,
                                    input logic [WORD_W-1:0] d);
    regsT n;
    n = r;
    case (s)
      SEL_A:  n.a = d[ACC_W-1:0];
      SEL_B:  n.b = d[ACC_W-1:0];
      SEL_D: begin
        n.a = d[WORD_W-1:ACC_W];
        n.b = d[ACC_W-1:0];
      end
      SEL_X:  n.x = d;
      SEL_Y:  n.y = d;
      SEL_SP: n.sp = d;
      default: n = r;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/regmove_ctrl.sv
module regmove_ctrl
  import regmove_pkg::*;
(
  input  logic             cmdValid,
  input  logic [OP_W-1:0]  cmdOp,
  input  logic [SEL_W-1:0] srcSel,
  input  logic [SEL_W-1:0] dstSel,
  output ctrlT             ctrl
);
  logic srcAcc, srcWide, dstAcc, dstWide, srcOk, dstOk;

  always_comb begin
    srcAcc  = isAcc(srcSel);
    srcWide = isWide(srcSel);
    dstAcc  = isAcc(dstSel);
    dstWide = isWide(dstSel);
    srcOk   = srcAcc | srcWide;
    dstOk   = dstAcc | dstWide;
  end

  always_comb begin
    ctrl          = '0;
    ctrl.srcSel   = srcSel;
    ctrl.dstSel   = dstSel;
    ctrl.dstData  = DS_COPY;
    if (cmdValid) begin
      case (cmdOp)
        OP_XFER: begin
          if (srcOk && dstOk) begin
            ctrl.wrDst   = 1'b1;
            ctrl.dstData = (srcAcc && dstWide) ? DS_SEXT : DS_COPY;
          end
        end
        OP_SEXT: begin
          if (srcAcc && dstWide) begin
            ctrl.wrDst   = 1'b1;
            ctrl.dstData = DS_SEXT;
          end
        end
        OP_ACCMOVE: begin
          if (srcAcc && dstAcc) begin
            ctrl.wrDst  = 1'b1;
            ctrl.flagWr = 1'b1;
          end
        end
        OP_SWAP: begin
          if (srcOk && dstOk) begin
            ctrl.wrDst    = 1'b1;
            ctrl.wrSrc    = 1'b1;
            ctrl.dstData  = (srcAcc && dstWide) ? DS_ZEXT : DS_COPY;
            ctrl.srcZext  = dstAcc && srcWide;
            ctrl.wideLast = dstWide;
          end
        end
        OP_LOAD: begin
          if (dstOk) begin
            ctrl.wrDst    = 1'b1;
            ctrl.dstData  = DS_LOAD;
            ctrl.flagWr   = 1'b1;
            ctrl.flagWide = dstWide;
          end
        end
        default: ctrl.wrDst = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/regmove_datapath.sv
module regmove_datapath
  import regmove_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic [WORD_W-1:0] loadData,
  output regsT              regs,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV
);
  regsT              cur, nxt, stage;
  logic [WORD_W-1:0] srcVal, dstVal, dstWrData, srcWrData;
  logic              resNeg, resZero;

  always_comb begin
    srcVal = readReg(cur, ctrl.srcSel);
    dstVal = readReg(cur, ctrl.dstSel);
    case (ctrl.dstData)
      DS_SEXT: dstWrData = {{ACC_W{srcVal[ACC_W-1]}}, srcVal[ACC_W-1:0]};
      DS_ZEXT: dstWrData = {{ACC_W{1'b0}}, srcVal[ACC_W-1:0]};
      DS_LOAD: dstWrData = loadData;
      default: dstWrData = srcVal;
    endcase
    srcWrData = ctrl.srcZext ? {{ACC_W{1'b0}}, dstVal[ACC_W-1:0]} : dstVal;
  end

  always_comb begin
    stage = cur;
    nxt   = cur;
    if (ctrl.wideLast) begin
      if (ctrl.wrSrc) stage = writeReg(cur, ctrl.srcSel, srcWrData);
      nxt = stage;
      if (ctrl.wrDst) nxt = writeReg(stage, ctrl.dstSel, dstWrData);
    end else begin
      if (ctrl.wrDst) stage = writeReg(cur, ctrl.dstSel, dstWrData);
      nxt = stage;
      if (ctrl.wrSrc) nxt = writeReg(stage, ctrl.srcSel, srcWrData);
    end
  end

  always_comb begin
    if (ctrl.flagWide) begin
      resNeg  = dstWrData[WORD_W-1];
      resZero = (dstWrData == '0);
    end else begin
      resNeg  = dstWrData[ACC_W-1];
      resZero = (dstWrData[ACC_W-1:0] == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur   <= '0;
      flagN <= 1'b0;
      flagZ <= 1'b0;
      flagV <= 1'b0;
    end else begin
      cur <= nxt;
      if (ctrl.flagWr) begin
        flagN <= resNeg;
        flagZ <= resZero;
        flagV <= 1'b0;
      end
    end
  end

  assign regs = cur;
endmodule

// File: rtl/regmove_unit.sv
module regmove_unit
  import regmove_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [OP_W-1:0]   cmdOp,
  input  logic [SEL_W-1:0]  srcSel,
  input  logic [SEL_W-1:0]  dstSel,
  input  logic [WORD_W-1:0] loadData,
  output logic [ACC_W-1:0]  regA,
  output logic [ACC_W-1:0]  regB,
  output logic [WORD_W-1:0] regX,
  output logic [WORD_W-1:0] regY,
  output logic [WORD_W-1:0] regSp,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV
);
  ctrlT ctrl;
  regsT regs;

  regmove_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .srcSel   (srcSel),
    .dstSel   (dstSel),
    .ctrl     (ctrl)
  );

  regmove_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .loadData (loadData),
    .regs     (regs),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagV    (flagV)
  );

  assign regA  = regs.a;
  assign regB  = regs.b;
  assign regX  = regs.x;
  assign regY  = regs.y;
  assign regSp = regs.sp;
endmodule

// File: rtl/regmove_checker.sv
module regmove_checker
  import regmove_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [OP_W-1:0]   cmdOp,
  input logic [SEL_W-1:0]  srcSel,
  input logic [SEL_W-1:0]  dstSel,
  input logic [WORD_W-1:0] loadData,
  input logic [ACC_W-1:0]  regA,
  input logic [ACC_W-1:0]  regB,
  input logic [WORD_W-1:0] regX,
  input logic [WORD_W-1:0] regY,
  input logic [WORD_W-1:0] regSp,
  input logic              flagN,
  input logic              flagZ,
  input logic              flagV
);
  logic [ACC_W*2+WORD_W*3+2:0] allState;
  assign allState = {regA, regB, regX, regY, regSp, flagN, flagZ, flagV};

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(allState));

  a_r10_reserved_op: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp > 3'd4) |=> $stable(allState));

  a_r5_xfer_keeps_flags: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp == 3'd0 || cmdOp == 3'd3)) |=> $stable({flagN, flagZ, flagV}));

  a_r9_load_clears_v: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd2 && (isAcc(dstSel) || isWide(dstSel))) |=> !flagV);

  a_r9_load_x: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd2 && dstSel == SEL_X) |=> (regX == $past(loadData)));

  a_r3_sext_a_to_x: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd0 && srcSel == SEL_A && dstSel == SEL_X)
      |=> (regX == {{ACC_W{$past(regA[ACC_W-1])}}, $past(regA)}));

  a_r7_swap_xy: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd1 && srcSel == SEL_X && dstSel == SEL_Y)
      |=> (regX == $past(regY) && regY == $past(regX)));
endmodule

bind regmove_unit regmove_checker u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .srcSel(srcSel), .dstSel(dstSel), .loadData(loadData),
  .regA(regA), .regB(regB), .regX(regX), .regY(regY), .regSp(regSp),
  .flagN(flagN), .flagZ(flagZ), .flagV(flagV)
);

// File: tb/regmove_unit_tb.sv
module regmove_unit_tb;
  localparam logic [2:0] T_XFER = 3'd0, T_SWAP = 3'd1, T_LOAD = 3'd2,
                         T_SEXT = 3'd3, T_ACC = 3'd4;
  localparam logic [2:0] RA = 3'd0, RB = 3'd1, RD = 3'd4, RX = 3'd5, RY = 3'd6, RS = 3'd7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0, srcSel = '0, dstSel = '0;
  logic [15:0] loadData = '0;
  logic [7:0] regA, regB;
  logic [15:0] regX, regY, regSp;
  logic flagN, flagZ, flagV;

  logic [7:0] eA, eB;
  logic [15:0] eX, eY, eSp;
  logic eN, eZ, eV;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  regmove_unit u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .srcSel(srcSel), .dstSel(dstSel), .loadData(loadData),
    .regA(regA), .regB(regB), .regX(regX), .regY(regY), .regSp(regSp),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV)
  );

  task automatic doCmd(input logic [2:0] op, input logic [2:0] s, input logic [2:0] d,
                       input logic [15:0] ld, input logic valid = 1'b1);
    @(negedge clk);
    cmdOp = op; srcSel = s; dstSel = d; loadData = ld; cmdValid = valid;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic checkState(input string tag);
    checks++;
    if ({regA, regB, regX, regY, regSp, flagN, flagZ, flagV} !==
        {eA, eB, eX, eY, eSp, eN, eZ, eV}) begin
      fails++;
      $display("FAIL %s: got A=%h B=%h X=%h Y=%h SP=%h NZV=%b%b%b exp A=%h B=%h X=%h Y=%h SP=%h NZV=%b%b%b",
               tag, regA, regB, regX, regY, regSp, flagN, flagZ, flagV,
               eA, eB, eX, eY, eSp, eN, eZ, eV);
    end
  endtask

  // load helper that also tracks the expected state
  task automatic ld(input logic [2:0] d, input logic [15:0] v);
    doCmd(T_LOAD, RA, d, v);
    case (d)
      RA: eA = v[7:0];
      RB: eB = v[7:0];
      RD: begin eA = v[15:8]; eB = v[7:0]; end
      RX: eX = v;
      RY: eY = v;
      default: eSp = v;
    endcase
    if (d == RA || d == RB) begin eN = v[7]; eZ = (v[7:0] == 8'h00); end
    else begin eN = v[15]; eZ = (v == 16'h0000); end
    eV = 1'b0;
  endtask

  task automatic t_reset();
    eA = 0; eB = 0; eX = 0; eY = 0; eSp = 0; eN = 0; eZ = 0; eV = 0;
    checkState("R1 reset state");
  endtask

  task automatic t_xfer16();
    ld(RX, 16'h1234);
    doCmd(T_XFER, RX, RY, 16'h0); eY = 16'h1234;
    checkState("R2 transfer X to Y");
    doCmd(T_XFER, RX, RD, 16'h0); eA = 8'h12; eB = 8'h34;
    checkState("R2 transfer X to D");
    doCmd(T_XFER, RD, RS, 16'h0); eSp = 16'h1234;
    checkState("R2 transfer D to SP");
  endtask

  task automatic t_sext();
    ld(RA, 16'h0085);
    doCmd(T_XFER, RA, RX, 16'h0); eX = 16'hFF85;
    checkState("R3 transfer A to X sign extends");
    ld(RB, 16'h007F);
    doCmd(T_SEXT, RB, RY, 16'h0); eY = 16'h007F;
    checkState("R3 sign-extend B to Y positive");
    doCmd(T_SEXT, RA, RD, 16'h0); eA = 8'hFF; eB = 8'h85;
    checkState("R3 sign-extend A to D");
  endtask

  task automatic t_trunc();
    ld(RX, 16'hABCD);
    doCmd(T_XFER, RX, RA, 16'h0); eA = 8'hCD;
    checkState("R4 transfer X to A low byte");
    ld(RD, 16'h1122);
    doCmd(T_XFER, RD, RA, 16'h0); eA = 8'h22;
    checkState("R4 transfer D to A takes B");
  endtask

  task automatic t_flagsKeep();
    ld(RS, 16'hFF80);
    ld(RY, 16'h0000);
    doCmd(T_XFER, RS, RB, 16'h0); eB = 8'h80;
    checkState("R5 transfer keeps flags");
    ld(RA, 16'h0001);
    doCmd(T_SEXT, RB, RX, 16'h0); eX = 16'hFF80;
    checkState("R5 sign-extend keeps flags");
  endtask

  task automatic t_accMove();
    ld(RA, 16'h0080);
    ld(RB, 16'h0005);
    doCmd(T_ACC, RA, RB, 16'h0); eB = 8'h80; eN = 1; eZ = 0; eV = 0;
    checkState("R6 accumulator move A to B negative");
    ld(RA, 16'h0000);
    ld(RB, 16'h0044);
    doCmd(T_ACC, RA, RB, 16'h0); eB = 8'h00; eN = 0; eZ = 1;
    checkState("R6 accumulator move zero");
    ld(RX, 16'h1111);
    doCmd(T_ACC, RX, RA, 16'h0);
    checkState("R6 accumulator move with X ignored");
  endtask

  task automatic t_swapEq();
    ld(RX, 16'h1111);
    ld(RY, 16'h2222);
    doCmd(T_SWAP, RX, RY, 16'h0); eX = 16'h2222; eY = 16'h1111;
    checkState("R7 exchange X and Y");
    ld(RA, 16'h005A);
    ld(RB, 16'h00A5);
    doCmd(T_SWAP, RA, RB, 16'h0); eA = 8'hA5; eB = 8'h5A;
    checkState("R7 exchange A and B");
    ld(RS, 16'hBEEF);
    doCmd(T_SWAP, RD, RS, 16'h0); eSp = 16'hA55A; eA = 8'hBE; eB = 8'hEF;
    checkState("R7 exchange D and SP");
  endtask

  task automatic t_swapMix();
    ld(RA, 16'h009C);
    ld(RX, 16'h1234);
    doCmd(T_SWAP, RA, RX, 16'h0); eA = 8'h34; eX = 16'h009C;
    checkState("R8 exchange A with X");
    ld(RB, 16'h0077);
    ld(RX, 16'hABCD);
    doCmd(T_SWAP, RX, RB, 16'h0); eB = 8'hCD; eX = 16'h0077;
    checkState("R8 exchange X with B");
    ld(RD, 16'h1234);
    doCmd(T_SWAP, RA, RD, 16'h0); eA = 8'h00; eB = 8'h12;
    checkState("R8 exchange A with D");
  endtask

  task automatic t_load();
    ld(RD, 16'h8001);
    checkState("R9 load D negative");
    ld(RA, 16'h1200);
    checkState("R9 load A uses low byte for Z");
    ld(RY, 16'h0080);
    checkState("R9 load Y wide sign");
  endtask

  task automatic t_ignore();
    doCmd(T_LOAD, RA, RX, 16'h5555, 1'b0);
    checkState("R10 no valid no change");
    doCmd(3'd5, RA, RB, 16'h0);
    doCmd(3'd7, RX, RY, 16'h0);
    checkState("R10 reserved op codes");
    doCmd(T_XFER, RX, 3'd2, 16'h0);
    doCmd(T_LOAD, RA, 3'd3, 16'h0000);
    doCmd(T_SWAP, 3'd2, RY, 16'h0);
    checkState("R10 unused register codes");
    doCmd(T_SEXT, RA, RB, 16'h0);
    doCmd(T_SEXT, RX, RA, 16'h0);
    checkState("R10 sign-extend with bad operands");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_xfer16();
    t_sext();
    t_trunc();
    t_flagsKeep();
    t_accMove();
    t_swapEq();
    t_swapMix();
    t_load();
    t_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule